// File: doc/BRIEF.md
# Debounced Change-of-State Input Capture

This block watches a group of digital input lines, samples them on ticks of an internal scan timer, and filters each line against contact bounce with one debounce setting common to the whole group. When any line settles on a new level, the complete filtered word is stored as a last-change snapshot and pushed into a history queue. An external inhibit line can stop queue writes. A per-line enable mask decides which changes raise a latched interrupt request.

Software uses a small word-addressed register port. It programs the scan period, the debounce count and the interrupt mask. It reads the snapshot, a combined control/status word, and the queue head. When the group is switched to output direction, the capture path is frozen and input activity has no effect.

The capture controller is a three-state machine. **ST_IDLE** waits for a filtered change. When a change arrives it latches the new word and moves to **ST_STORE**. **ST_STORE** updates the snapshot, pushes the word or records an overflow, and raises the interrupt. From there it returns to ST_IDLE, or stays in ST_STORE if another change arrives at once. Setting output direction moves any state to **ST_OFFLINE**. Clearing it leaves ST_OFFLINE for ST_IDLE, or for ST_STORE when a change is waiting.

Top module: `cos_capture`

## Requirements
- R1: The scan timer issues one tick every SCAN+1 clocks, where SCAN is the value at address 4. Input lines are examined only on ticks, so a new level cannot be accepted sooner than the number of ticks R2 requires.
- R2: A line takes its new level only after the synchronised sample has differed from the accepted level on DB+1 consecutive ticks, where DB is the value at address 3. A shorter excursion is discarded. With DB=0 the first differing tick is accepted.
- R3: Each accepted change stores the whole filtered word into the history queue. Reads at address 5 return entries oldest first, and each read removes one entry.
- R4: When the queue holds DEPTH entries, a further change is dropped and the sticky overflow bit (status bit 2) is set. Writing 1 to control bit 2 clears it.
- R5: Output `irq` rises when a change involves any line whose bit is 1 in the mask (address 2). It stays high until software writes 1 to control bit 1.
- R6: While `inhibit` is high, changes update the snapshot but write nothing into the queue.
- R7: With control bit 0 at 1 (output direction), input activity changes neither the snapshot, nor the queue, nor `irq`.
- R8: Address 0 returns the filtered word captured on the most recent accepted change.
- R9: The control/status word (address 1) holds the direction in bit 0, the pending interrupt in bit 1, overflow in bit 2, queue-empty in bit 3, queue-full in bit 4 and the entry count in bits 14:8. A queue read while empty returns 0 and leaves the count unchanged.
- R10: After reset, every register reads 0 except queue-empty, which reads 1, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| din | input | WIDTH | Raw input lines (asynchronous) |
| inhibit | input | 1 | High blocks queue writes |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops queue at address 5) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| irq | output | 1 | Latched interrupt request |

## Verification
The bench builds the block with its default parameters: a 32-line group, a 64-entry queue, an 8-bit debounce count and a 16-bit scan divider. The full queue depth is therefore reachable in a few hundred cycles, so the full, drop and overflow path is exercised for real. Small scan periods (1, 10 and 100 clocks) make the tick spacing and debounce windows short enough that filtered and accepted excursions can be timed deterministically against the tick grid.

// File: rtl/cos_pkg.sv
package cos_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STORE   = 2'd1,
        ST_OFFLINE = 2'd2
    } cap_state_t;

    localparam logic [2:0] A_LAST     = 3'd0;
    localparam logic [2:0] A_CTRL     = 3'd1;
    localparam logic [2:0] A_MASK     = 3'd2;
    localparam logic [2:0] A_DEBOUNCE = 3'd3;
    localparam logic [2:0] A_SCAN     = 3'd4;
    localparam logic [2:0] A_FIFO     = 3'd5;

    localparam int B_DIR   = 0;
    localparam int B_IRQ   = 1;
    localparam int B_OVF   = 2;
    localparam int B_EMPTY = 3;
    localparam int B_FULL  = 4;
    localparam int B_CNT   = 8;
endpackage

// File: rtl/cos_scan_timer.sv
module cos_scan_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= div;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/cos_debounce.sv
module cos_debounce #(
    parameter int WIDTH = 32,
    parameter int DB_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DB_W-1:0]  limit,
    input  logic [WIDTH-1:0] sample,
    output logic [WIDTH-1:0] stable,
    output logic [WIDTH-1:0] chg
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        logic [DB_W-1:0] cnt_q;
        logic            stab_q;
        logic            hit_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q  <= '0;
                stab_q <= 1'b0;
                hit_q  <= 1'b0;
            end else begin
                hit_q <= 1'b0;
                if (en) begin
                    if (sample[i] == stab_q) begin
                        cnt_q <= '0;
                    end else if (cnt_q >= limit) begin
                        stab_q <= sample[i];
                        cnt_q  <= '0;
                        hit_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end
        end

        assign stable[i] = stab_q;
        assign chg[i]    = hit_q;
    end

    AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(stable));  // R1
endmodule

// File: rtl/cos_hist_fifo.sv
module cos_hist_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full,
    output logic [$clog2(DEPTH):0] count
);
    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr_q, rptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign count   = cnt_q;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = empty ? '0 : mem[rptr_q];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr_q] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) begin
                wptr_q <= (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
            end
            if (do_pop) begin
                rptr_q <= (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);  // R4
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop) |=> (count == $past(count) + 1'b1));  // R3
    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);  // R9
endmodule

// File: rtl/cos_capture_ctl.sv
module cos_capture_ctl
    import cos_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] chg,
    input  logic [WIDTH-1:0] stable,
    input  logic [WIDTH-1:0] mask,
    input  logic             dir_out,
    input  logic             inhibit,
    input  logic             full,
    input  logic             irq_ack,
    input  logic             ovf_clr,
    output logic             push,
    output logic [WIDTH-1:0] push_data,
    output logic [WIDTH-1:0] last_q,
    output logic             irq_q,
    output logic             ovf_q
);
    cap_state_t       state_q, state_d;
    logic [WIDTH-1:0] snap_q;
    logic             snap_irq_q;
    logic             snap_load, store_go, ovf_set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        snap_load = !dir_out && (|chg);
        store_go  = 1'b0;
        push      = 1'b0;
        ovf_set   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (dir_out)        state_d = ST_OFFLINE;
                else if (|chg)      state_d = ST_STORE;
            end
            ST_STORE: begin
                store_go = !dir_out;
                push     = !dir_out && !inhibit && !full;
                ovf_set  = !dir_out && !inhibit && full;
                if (dir_out)        state_d = ST_OFFLINE;
                else if (|chg)      state_d = ST_STORE;
                else                state_d = ST_IDLE;
            end
            ST_OFFLINE: begin
                if (!dir_out)       state_d = (|chg) ? ST_STORE : ST_IDLE;
            end
            default:                state_d = ST_IDLE;
        endcase
    end

    assign push_data = snap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q     <= '0;
            snap_irq_q <= 1'b0;
            last_q     <= '0;
            irq_q      <= 1'b0;
            ovf_q      <= 1'b0;
        end else begin
            if (snap_load) begin
                snap_q     <= stable;
                snap_irq_q <= |(chg & mask);
            end
            if (store_go) begin
                last_q <= snap_q;
            end
            irq_q <= (irq_q && !irq_ack) || (store_go && snap_irq_q);
            ovf_q <= (ovf_q && !ovf_clr) || ovf_set;
        end
    end

    AST_IRQ_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !irq_ack) |=> irq_q);  // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !ovf_clr) |=> ovf_q);  // R4
    AST_OUTMODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_out && state_q != ST_STORE) |=> $stable(last_q));  // R7
    AST_INHIBIT_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && state_q == ST_STORE) |-> !push);  // R6
endmodule

// File: rtl/cos_capture.sv
module cos_capture
    import cos_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int DEPTH = 64,
    parameter int DB_W  = 8,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  logic             inhibit,
    input  logic [2:0]       reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             irq
);
    localparam int CNT_W = $clog2(DEPTH) + 1;

    logic [WIDTH-1:0] sync1_q, sync2_q;
    logic [WIDTH-1:0] mask_q;
    logic [DB_W-1:0]  db_q;
    logic [DIV_W-1:0] scan_q;
    logic             dir_q;
    logic             tick;
    logic [WIDTH-1:0] stable, chg;
    logic             push, irq_ack, ovf_clr, pop;
    logic [WIDTH-1:0] push_data, last_q, fifo_rdata;
    logic             irq_q, ovf_q, empty, full;
    logic [CNT_W-1:0] count;
    logic             wr_ctrl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
        end else begin
            sync1_q <= din;
            sync2_q <= sync1_q;
        end
    end

    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign irq_ack = wr_ctrl && reg_wdata[B_IRQ];
    assign ovf_clr = wr_ctrl && reg_wdata[B_OVF];
    assign pop     = reg_rd && (reg_addr == A_FIFO);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= 1'b0;
            mask_q <= '0;
            db_q   <= '0;
            scan_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_CTRL:     dir_q  <= reg_wdata[B_DIR];
                A_MASK:     mask_q <= reg_wdata[WIDTH-1:0];
                A_DEBOUNCE: db_q   <= reg_wdata[DB_W-1:0];
                A_SCAN:     scan_q <= reg_wdata[DIV_W-1:0];
                default: ;
            endcase
        end
    end

    cos_scan_timer #(.DIV_W(DIV_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (scan_q),
        .tick  (tick)
    );

    cos_debounce #(.WIDTH(WIDTH), .DB_W(DB_W)) u_debounce (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (tick && !dir_q),
        .limit  (db_q),
        .sample (sync2_q),
        .stable (stable),
        .chg    (chg)
    );

    cos_capture_ctl #(.WIDTH(WIDTH)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .chg       (chg),
        .stable    (stable),
        .mask      (mask_q),
        .dir_out   (dir_q),
        .inhibit   (inhibit),
        .full      (full),
        .irq_ack   (irq_ack),
        .ovf_clr   (ovf_clr),
        .push      (push),
        .push_data (push_data),
        .last_q    (last_q),
        .irq_q     (irq_q),
        .ovf_q     (ovf_q)
    );

    cos_hist_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (push_data),
        .pop   (pop),
        .rdata (fifo_rdata),
        .empty (empty),
        .full  (full),
        .count (count)
    );

    assign irq = irq_q;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_LAST:     reg_rdata[WIDTH-1:0] = last_q;
            A_CTRL: begin
                reg_rdata[B_DIR]             = dir_q;
                reg_rdata[B_IRQ]             = irq_q;
                reg_rdata[B_OVF]             = ovf_q;
                reg_rdata[B_EMPTY]           = empty;
                reg_rdata[B_FULL]            = full;
                reg_rdata[B_CNT +: CNT_W]    = count;
            end
            A_MASK:     reg_rdata[WIDTH-1:0] = mask_q;
            A_DEBOUNCE: reg_rdata[DB_W-1:0]  = db_q;
            A_SCAN:     reg_rdata[DIV_W-1:0] = scan_q;
            A_FIFO:     reg_rdata[WIDTH-1:0] = fifo_rdata;
            default:    reg_rdata = '0;
        endcase
    end

    AST_IRQ_PIN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);  // R5
endmodule

// File: tb/cos_capture_bench.sv
`timescale 1ns/1ps
module cos_capture_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] din;
    logic        inhibit;
    logic [2:0]  reg_addr;
    logic        reg_wr, reg_rd;
    logic [31:0] reg_wdata, reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] cur;

    always #2.5 clk = ~clk;

    cos_capture u_cos_capture (
        .clk(clk), .rst_n(rst_n), .din(din), .inhibit(inhibit),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic set_din(input logic [31:0] v);
        @(negedge clk);
        din = v; cur = v;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(3'd0, v); chk("R10 last", v, 32'h0);
        rd(3'd1, v); chk("R10 status", v, 32'h0000_0008);
        rd(3'd2, v); chk("R10 mask", v, 32'h0);
        rd(3'd3, v); chk("R10 debounce", v, 32'h0);
        rd(3'd4, v); chk("R10 scan", v, 32'h0);
        chk("R10 irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_capture;
        logic [31:0] v;
        set_din(32'h0000_00F0); clks(10);
        rd(3'd0, v); chk("R8 last first", v, 32'h0000_00F0);
        set_din(32'h0F00_00F0); clks(10);
        rd(3'd0, v); chk("R8 last second", v, 32'h0F00_00F0);
        rd(3'd1, v); chk("R9 count two", v, 32'h0000_0200);
        rd(3'd5, v); chk("R3 oldest", v, 32'h0000_00F0);
        rd(3'd5, v); chk("R3 next", v, 32'h0F00_00F0);
        rd(3'd5, v); chk("R9 empty read zero", v, 32'h0);
        rd(3'd1, v); chk("R9 empty status", v, 32'h0000_0008);
    endtask

    task automatic t_debounce;
        logic [31:0] v;
        wr(3'd4, 32'd9); wr(3'd3, 32'd3);
        set_din(32'h0F00_00F2); clks(20);
        set_din(32'h0F00_00F0); clks(60);
        rd(3'd0, v); chk("R2 glitch rejected", v, 32'h0F00_00F0);
        rd(3'd1, v); chk("R2 glitch no entry", v, 32'h0000_0008);
        set_din(32'h0F00_00F2); clks(25);
        rd(3'd0, v); chk("R2 not yet accepted", v, 32'h0F00_00F0);
        clks(60);
        rd(3'd0, v); chk("R2 accepted", v, 32'h0F00_00F2);
        rd(3'd5, v); chk("R2 entry", v, 32'h0F00_00F2);
    endtask

    task automatic t_scan;
        logic [31:0] v;
        wr(3'd4, 32'd99); wr(3'd3, 32'd1);
        set_din(32'h0F00_00F0); clks(90);
        rd(3'd0, v); chk("R1 slow scan early", v, 32'h0F00_00F2);
        clks(130);
        rd(3'd0, v); chk("R1 slow scan accepted", v, 32'h0F00_00F0);
        rd(3'd5, v); chk("R1 entry", v, 32'h0F00_00F0);
        wr(3'd4, 32'd0); wr(3'd3, 32'd0);
        clks(110);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        wr(3'd2, 32'h0000_0010);
        set_din(cur ^ 32'h1); clks(10);
        chk("R5 masked no irq", {31'h0, irq}, 32'h0);
        set_din(cur ^ 32'h10); clks(10);
        chk("R5 unmasked irq", {31'h0, irq}, 32'h1);
        rd(3'd1, v); chk("R5 status pending", v & 32'h2, 32'h2);
        set_din(cur ^ 32'h1); clks(10);
        chk("R5 irq latched", {31'h0, irq}, 32'h1);
        wr(3'd1, 32'h2); clks(2);
        chk("R5 irq acked", {31'h0, irq}, 32'h0);
        wr(3'd2, 32'h0);
        for (int i = 0; i < 3; i++) rd(3'd5, v);
        rd(3'd1, v); chk("R3 drained", v, 32'h0000_0008);
    endtask

    task automatic t_inhibit;
        logic [31:0] v;
        inhibit = 1'b1;
        set_din(cur ^ 32'h100); clks(10);
        rd(3'd0, v); chk("R6 last updated", v, cur);
        inhibit = 1'b0; clks(5);
        rd(3'd1, v); chk("R6 no entry", v, 32'h0000_0008);
    endtask

    task automatic t_outmode;
        logic [31:0] v, prev;
        prev = cur;
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd1, 32'h1);
        rd(3'd1, v); chk("R9 dir bit", v, 32'h0000_0009);
        set_din(prev ^ 32'hFF00); clks(20);
        rd(3'd0, v); chk("R7 last frozen", v, prev);
        rd(3'd1, v); chk("R7 no entry", v, 32'h0000_0009);
        chk("R7 no irq", {31'h0, irq}, 32'h0);
        set_din(prev); clks(10);
        wr(3'd1, 32'h0); clks(10);
        rd(3'd0, v); chk("R7 last after return", v, prev);
        chk("R7 no irq after return", {31'h0, irq}, 32'h0);
        wr(3'd2, 32'h0);
    endtask

    task automatic t_overflow;
        logic [31:0] v;
        for (int i = 1; i <= 66; i++) begin
            set_din(32'h1000_0000 | i);
            clks(8);
        end
        rd(3'd1, v); chk("R4 full and overflow", v, 32'h0000_4014);
        rd(3'd0, v); chk("R8 last after drop", v, 32'h1000_0042);
        for (int i = 1; i <= 64; i++) begin
            rd(3'd5, v);
            chk("R3 order", v, 32'h1000_0000 | i);
        end
        rd(3'd1, v); chk("R4 overflow sticky", v, 32'h0000_000C);
        rd(3'd5, v); chk("R9 empty read", v, 32'h0);
        rd(3'd1, v); chk("R9 count held", v, 32'h0000_000C);
        wr(3'd1, 32'h4);
        rd(3'd1, v); chk("R4 overflow cleared", v, 32'h0000_0008);
    endtask

    initial begin
        rst_n = 1'b0; din = '0; cur = '0; inhibit = 1'b0;
        reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
        clks(4);
        rst_n = 1'b1;
        clks(2);
        t_reset;
        t_capture;
        t_debounce;
        t_scan;
        t_irq;
        t_inhibit;
        t_outmode;
        t_overflow;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule